// File: doc/BRIEF.md
# Display Command Parser and Window Addressing

This block sits behind a serial byte receiver in a small grey-level display controller. Every received byte arrives with a select line. When the select line is high the byte is pixel data. The block writes that byte into a frame memory of 80 rows by 64 bytes, where each byte packs two 4-bit pixels. It then moves the write position forward inside a rectangular window that software can program.

When the select line is low the byte belongs to a command. The block takes the opcode, collects as many argument bytes as that opcode needs, and then applies it. Three opcodes change state: the column window, the row window and the remap setting. The remap setting chooses between row-major and column-major stepping. All other known opcodes are analog or scan settings. They are counted correctly and then dropped. An opcode the block does not know raises a one-cycle error pulse.

The block has two outputs toward the rest of the controller: a registered write port into the frame memory, and a sticky redraw flag that the scan-out logic clears.

Top module: `oled_cmd_addr`

## Requirements
- R1: One clock after a byte is accepted with `dc_sel` high, `mem_we` is high for exactly one cycle. In that cycle `mem_wdata` equals the byte and `mem_addr` equals row*64 + column of the current position. `mem_we` stays low after any cycle that carries no data byte.
- R2: After reset, the column window is 0..63, the row window is 0..79, the position is column 0 / row 0, stepping is horizontal, and `mem_we`, `redraw` and `cmd_err` are low.
- R3: Opcode 0x15 is followed by two bytes: the first column and the last column of the window, each taken modulo 64. The current column is set to the first one.
- R4: Opcode 0x75 is followed by two bytes: the first row and the last row of the window, each taken modulo 80. The current row is set to the first one.
- R5: In horizontal stepping, each data byte increments the column. When the column goes past the last column, it returns to the first column and the row increments. When the row goes past the last row, it returns to the first row. Both wraps can happen on the same byte.
- R6: Opcode 0xA0 is followed by one byte, which becomes the remap setting. If bit 2 of that byte is 1, stepping is vertical: the row increments, and when it goes past the last row it returns to the first row and the column increments. When the column goes past the last column, it returns to the first column. If bit 2 is 0, stepping is horizontal again.
- R7: Argument counts are fixed per opcode. These opcodes take one argument byte: 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF. Opcode 0xB8 takes eight. These take none: 0x84–0x86, 0xA4–0xA7, 0xAE, 0xAF and 0xE3. An argument byte is never read as an opcode.
- R8: Any other opcode counts as a command with no arguments. `cmd_err` is high for exactly one cycle, one clock after that byte, and the next command byte is read as an opcode.
- R9: Whenever `dc_sel` is high, any partially collected command is dropped. The next command byte is read as a new opcode.
- R10: Every data byte sets `redraw`. `redraw_clr` clears it. When a data byte and `redraw_clr` arrive in the same cycle, `redraw` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_in | input | 8 | Received byte |
| dc_sel | input | 1 | 1 = pixel data, 0 = command byte |
| redraw_clr | input | 1 | Scan-out acknowledges the redraw request |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | 13 | Frame memory byte address, row*64 + column |
| mem_wdata | output | 8 | Frame memory write data (two pixels) |
| redraw | output | 1 | Sticky flag: frame memory has changed |
| cmd_err | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
Two pairs of functions can act in the same cycle. First, a single data byte can both return the column to the start of the window and return the row to the start of the window. This happens when the position is at the bottom-right corner of the window. Second, a data byte that sets `redraw` can arrive in the same cycle as `redraw_clr`. The bench provokes the first case by filling a small shifted window until the write position passes its last cell. A scoreboard judges it: each address expected from the requirements is compared with the write that comes out. The bench provokes the second case by driving a data byte and `redraw_clr` on the same edge, and judges it by checking that `redraw` is still high one clock later.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

  localparam logic [7:0] OP_COL_WIN = 8'h15;
  localparam logic [7:0] OP_ROW_WIN = 8'h75;
  localparam logic [7:0] OP_REMAP   = 8'hA0;
  localparam int         VERT_BIT   = 2;
  localparam int         CNT_W      = 4;

  typedef struct packed {
    logic             known;
    logic [CNT_W-1:0] nargs;
  } op_info_t;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] first;
    logic [7:0] last;
  } cmd_t;

  function automatic op_info_t op_lookup(input logic [7:0] op);
    op_info_t r;
    r.known = 1'b1;
    r.nargs = '0;
    case (op)
      8'h15, 8'h75:                                   r.nargs = CNT_W'(2);
      8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:       r.nargs = CNT_W'(1);
      8'hB8:                                          r.nargs = CNT_W'(8);
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6,
      8'hA7, 8'hAE, 8'hAF, 8'hE3:                     r.nargs = '0;
      default:                                        r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/oled_cmd_collect.sv
module oled_cmd_collect
  import oled_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       dc_sel,
  input  logic [7:0] byte_in,
  output logic       apply_vld,
  output cmd_t       apply,
  output logic       bad_op
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] need_q, need_d;
  logic [7:0]       op_q, op_d;
  logic [7:0]       first_q, first_d;
  logic             cnt_en;
  op_info_t         info;

  assign info   = op_lookup(byte_in);
  assign cnt_en = dc_sel | byte_vld;

  always_comb begin
    cnt_d     = cnt_q;
    need_d    = need_q;
    op_d      = op_q;
    first_d   = first_q;
    apply_vld = 1'b0;
    bad_op    = 1'b0;
    apply     = '{op: op_q, first: first_q, last: byte_in};
    if (dc_sel) begin
      cnt_d = '0;
    end else if (byte_vld) begin
      if (cnt_q == '0) begin
        op_d     = byte_in;
        apply.op = byte_in;
        if (info.nargs == '0) begin
          apply_vld = info.known;
          bad_op    = ~info.known;
        end else begin
          need_d = info.nargs;
          cnt_d  = CNT_W'(1);
        end
      end else begin
        if (cnt_q == CNT_W'(1)) first_d = byte_in;
        if (cnt_q == need_q) begin
          apply_vld = 1'b1;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      need_q  <= '0;
      op_q    <= '0;
      first_q <= '0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      need_q  <= need_d;
      op_q    <= op_d;
      first_q <= first_d;
    end
  end

endmodule

// File: rtl/oled_addr_gen.sv
module oled_addr_gen
  import oled_cmd_pkg::*;
#(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_vld,
  input  cmd_t              apply,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [COL_W-1:0] col_q, col_d, cs_q, cs_d, ce_q, ce_d;
  logic [ROW_W-1:0] row_q, row_d, rs_q, rs_d, re_q, re_d;
  logic             vert_q, vert_d;
  logic [COL_W:0]   col_inc, col_adv;
  logic [ROW_W:0]   row_inc, row_adv;
  logic             col_wrap, row_wrap;
  logic             upd_en;

  assign col_inc  = {1'b0, col_q} + (COL_W+1)'(1);
  assign row_inc  = {1'b0, row_q} + (ROW_W+1)'(1);
  assign cur_addr = ADDR_W'(32'(row_q) * COLS + 32'(col_q));
  assign upd_en   = apply_vld | step;

  always_comb begin
    col_adv  = {1'b0, col_q};
    row_adv  = {1'b0, row_q};
    col_wrap = 1'b0;
    row_wrap = 1'b0;
    if (vert_q) begin
      row_wrap = row_inc > {1'b0, re_q};
      row_adv  = row_wrap ? {1'b0, rs_q} : row_inc;
      col_adv  = row_wrap ? col_inc : {1'b0, col_q};
      col_wrap = col_adv > {1'b0, ce_q};
    end else begin
      col_wrap = col_inc > {1'b0, ce_q};
      col_adv  = col_wrap ? {1'b0, cs_q} : col_inc;
      row_adv  = col_wrap ? row_inc : {1'b0, row_q};
      row_wrap = row_adv > {1'b0, re_q};
    end
  end

  always_comb begin
    col_d  = col_q;
    cs_d   = cs_q;
    ce_d   = ce_q;
    row_d  = row_q;
    rs_d   = rs_q;
    re_d   = re_q;
    vert_d = vert_q;
    if (apply_vld) begin
      case (apply.op)
        OP_COL_WIN: begin
          cs_d  = COL_W'(32'(apply.first) % COLS);
          col_d = COL_W'(32'(apply.first) % COLS);
          ce_d  = COL_W'(32'(apply.last) % COLS);
        end
        OP_ROW_WIN: begin
          rs_d  = ROW_W'(32'(apply.first) % ROWS);
          row_d = ROW_W'(32'(apply.first) % ROWS);
          re_d  = ROW_W'(32'(apply.last) % ROWS);
        end
        OP_REMAP: vert_d = apply.last[VERT_BIT];
        default: ;
      endcase
    end else if (step) begin
      if (vert_q) begin
        row_d = row_adv[ROW_W-1:0];
        col_d = col_wrap ? cs_q : col_adv[COL_W-1:0];
      end else begin
        col_d = col_adv[COL_W-1:0];
        row_d = row_wrap ? rs_q : row_adv[ROW_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      cs_q   <= '0;
      ce_q   <= COL_W'(COLS - 1);
      row_q  <= '0;
      rs_q   <= '0;
      re_q   <= ROW_W'(ROWS - 1);
      vert_q <= 1'b0;
    end else if (upd_en) begin
      col_q  <= col_d;
      cs_q   <= cs_d;
      ce_q   <= ce_d;
      row_q  <= row_d;
      rs_q   <= rs_d;
      re_q   <= re_d;
      vert_q <= vert_d;
    end
  end

endmodule

// File: rtl/oled_cmd_addr.sv
module oled_cmd_addr
  import oled_cmd_pkg::*;
#(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              dc_sel,
  input  logic              redraw_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              redraw,
  output logic              cmd_err
);

  logic              apply_vld;
  cmd_t              apply;
  logic              bad_op;
  logic              data_stb;
  logic [ADDR_W-1:0] cur_addr;
  logic              we_d, redraw_d, err_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        wdata_d;

  assign data_stb = byte_vld & dc_sel;

  oled_cmd_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .dc_sel    (dc_sel),
    .byte_in   (byte_in),
    .apply_vld (apply_vld),
    .apply     (apply),
    .bad_op    (bad_op)
  );

  oled_addr_gen #(.COLS(COLS), .ROWS(ROWS)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply_vld (apply_vld),
    .apply     (apply),
    .step      (data_stb),
    .cur_addr  (cur_addr)
  );

  always_comb begin
    we_d     = data_stb;
    addr_d   = data_stb ? cur_addr : mem_addr;
    wdata_d  = data_stb ? byte_in : mem_wdata;
    err_d    = bad_op;
    redraw_d = redraw;
    if (redraw_clr) redraw_d = 1'b0;
    if (data_stb)   redraw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      redraw    <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      mem_we    <= we_d;
      mem_addr  <= addr_d;
      mem_wdata <= wdata_d;
      redraw    <= redraw_d;
      cmd_err   <= err_d;
    end
  end

endmodule

// File: rtl/oled_cmd_addr_chk.sv
module oled_cmd_addr_chk #(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic [7:0]        byte_in,
  input logic              dc_sel,
  input logic              redraw_clr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              redraw,
  input logic              cmd_err
);

  AST_WRITE_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && dc_sel) |=> (mem_we && mem_wdata == $past(byte_in))); // R1

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && dc_sel) |=> !mem_we); // R1

  AST_ADDR_IN_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(mem_addr) < ROWS * COLS)); // R4

  AST_REDRAW_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && dc_sel) |=> redraw); // R10

  AST_REDRAW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_clr && !(byte_vld && dc_sel)) |=> !redraw); // R10

  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $past(byte_vld && !dc_sel)); // R8

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err); // R8

endmodule

bind oled_cmd_addr oled_cmd_addr_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (.*);

// File: tb/oled_cmd_addr_tb.sv
module oled_cmd_addr_tb;

  localparam int COLS = 64;
  localparam int ROWS = 80;

  typedef struct {
    int    addr;
    int    data;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        dc_sel = 1'b0;
  logic        redraw_clr = 1'b0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        redraw;
  logic        cmd_err;

  int   total = 0;
  int   bad   = 0;
  int   err_seen = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  int m_col, m_row, m_cs, m_ce, m_rs, m_re;
  bit m_vert;

  always #5 clk = ~clk;

  oled_cmd_addr u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .dc_sel(dc_sel), .redraw_clr(redraw_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .redraw(redraw),
    .cmd_err(cmd_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected write", int'(mem_addr), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(mem_addr) == e.addr, {e.tag, " addr"}, int'(mem_addr), e.addr);
        check(int'(mem_wdata) == e.data, {e.tag, " data"}, int'(mem_wdata), e.data);
      end
    end
    if (rst_n && cmd_err) err_seen++;
  end

  task automatic put(input logic dc, input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1;
    dc_sel   = dc;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
    dc_sel   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    put(1'b0, b);
  endtask

  task automatic model_step();
    if (m_vert) begin
      m_row++;
      if (m_row > m_re) begin m_row = m_rs; m_col++; end
      if (m_col > m_ce) m_col = m_cs;
    end else begin
      m_col++;
      if (m_col > m_ce) begin m_col = m_cs; m_row++; end
      if (m_row > m_re) m_row = m_rs;
    end
  endtask

  task automatic dat(input logic [7:0] b, input string tag);
    exp_t e;
    e.addr = m_row * COLS + m_col;
    e.data = int'(b);
    e.tag  = tag;
    sb.push_back(e);
    model_step();
    put(1'b1, b);
  endtask

  task automatic set_cols(input int a, input int b);
    cmd(8'h15); cmd(8'(a)); cmd(8'(b));
    m_cs = a % COLS; m_col = m_cs; m_ce = b % COLS;
  endtask

  task automatic set_rows(input int a, input int b);
    cmd(8'h75); cmd(8'(a)); cmd(8'(b));
    m_rs = a % ROWS; m_row = m_rs; m_re = b % ROWS;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_col = 0; m_row = 0; m_cs = 0; m_ce = COLS - 1; m_rs = 0; m_re = ROWS - 1; m_vert = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R2: reset state
    check(mem_we == 1'b0, "R2 mem_we", int'(mem_we), 0);
    check(redraw == 1'b0, "R2 redraw", int'(redraw), 0);
    check(cmd_err == 1'b0, "R2 cmd_err", int'(cmd_err), 0);
    // R2/R1: first write lands at 0 and steps horizontally across full row
    dat(8'hAB, "R2 first write");
    dat(8'hCD, "R1 second write");
    check(redraw == 1'b1, "R10 set by data", int'(redraw), 1);
    // R2: full-width wrap at column 63
    for (int i = 2; i < 64; i++) dat(8'(i), "R2 full row");
    dat(8'h11, "R2 default window wrap");

    // R10: clear, then clear colliding with data
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    check(redraw == 1'b0, "R10 cleared", int'(redraw), 0);
    begin
      exp_t e;
      e.addr = m_row * COLS + m_col; e.data = 8'h5A; e.tag = "R10 collide";
      sb.push_back(e);
      model_step();
      @(negedge clk);
      byte_vld = 1'b1; dc_sel = 1'b1; byte_in = 8'h5A; redraw_clr = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0; dc_sel = 1'b0; redraw_clr = 1'b0;
      check(redraw == 1'b1, "R10 set wins over clear", int'(redraw), 1);
    end

    // R3/R4/R5: window with modulo arguments, horizontal double wrap
    set_cols(70, 8);     // 70 mod 64 = 6
    set_rows(250, 11);   // 250 mod 80 = 10
    for (int i = 0; i < 7; i++) dat(8'(8'h20 + i), "R5 horizontal window");
    check(m_col == 7 && m_row == 10, "R5 model corner", m_col, 7);

    // R6: vertical stepping
    cmd(8'hA0); cmd(8'h04); m_vert = 1'b1;
    set_cols(2, 3);
    set_rows(10, 12);
    for (int i = 0; i < 7; i++) dat(8'(8'h40 + i), "R6 vertical window");
    cmd(8'hA0); cmd(8'h00); m_vert = 1'b0;
    dat(8'h4F, "R6 back to horizontal");
    dat(8'h50, "R6 back to horizontal");

    // R7: argument counts
    cmd(8'h81); cmd(8'h75);          // 0x75 is an argument here
    cmd(8'hA4);                      // zero-argument
    cmd(8'hAD); cmd(8'h15);
    set_cols(20, 21);
    dat(8'h61, "R7 one-arg opcodes");
    cmd(8'hB8);
    for (int i = 0; i < 8; i++) cmd(8'h15);
    cmd(8'hE3); cmd(8'hAE);
    set_rows(30, 31);
    dat(8'h62, "R7 eight-arg opcode");
    idle(2);
    check(err_seen == 0, "R7 no error on known opcodes", err_seen, 0);

    // R8: unknown opcode
    cmd(8'h00);
    idle(1);
    check(err_seen == 1, "R8 error pulse", err_seen, 1);
    check(cmd_err == 1'b0, "R8 pulse ends", int'(cmd_err), 0);
    cmd(8'hFF);
    idle(1);
    check(err_seen == 2, "R8 second unknown", err_seen, 2);
    set_cols(4, 5);
    dat(8'h70, "R8 next byte is opcode");

    // R9: partial command abandoned by data
    cmd(8'h15); cmd(8'h09);
    dat(8'h71, "R9 data during partial command");
    set_cols(1, 1);
    dat(8'h72, "R9 fresh opcode after abandon");
    idle(2);
    check(err_seen == 2, "R9 no spurious error", err_seen, 2);

    idle(3);
    check(sb.size() == 0, "R1 all writes seen", sb.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule